// File: doc/BRIEF.md
# Banked GPIO Register File

This block is the register side of a general-purpose I/O controller. Software reaches it over a simple 32-bit register bus with an address, a write enable, write data and read data. The I/O lines are split into banks of eight. Each bank has two registers. The value register sets the level driven on output lines. The mode register picks, for each line, whether it is an input or an output. The block drives output values and output enables to the pads. It also brings the pad levels back in through a two-flop synchronizer so that software can read them.

Bank addresses do not run straight through. A 16-byte window starting at 0x90 belongs to a separate interrupt-configuration block. Any bank whose computed base would fall at or above that window is moved up by 0x10. Accesses to the window do not touch the banks. Instead, the block passes the window hit, the write enable and the word index inside the window out to the interrupt block, and returns that block's read data. Read data is registered, so `busRdData` shows the register that `busAddr` selected on the previous clock edge.

Top module: `pin_bank_ctrl`

## Requirements
- R1: Bank b (counted from 0) has base address (b+1)*8 before any window shift. Its value register sits at base+0x0 and its mode register at base+0x4. Read data appears on `busRdData` one clock after the address is presented, with line k of the bank at bit k.
- R2: A computed bank base of 0x90 or higher is raised by 0x10. No bank register ever decodes inside 0x90–0x9F. With 148 lines, bank 16 is at 0x88, bank 17 at 0xA0 and bank 18 at 0xA8.
- R3: A mode bit of 1 makes the line an input with `padOe` low. A mode bit of 0 makes it an output with `padOe` high. `padOut` always shows the line's value bit.
- R4: The value register keeps what was written whatever the mode is. A value preloaded while a line is an input is driven as soon as the mode bit is cleared, with no other change to `padOut`.
- R5: A read of the value register returns the synchronized pad level for input lines and the value bit for output lines, bit by bit within one bank.
- R6: Pad inputs pass through two flops before read-back. A pad change made just before a read address is presented is not seen by that read or the next one, and it is seen by a read issued two cycles later.
- R7: Addresses 0x90, 0x94, 0x98 and 0x9C assert `irqSel` with `irqIdx` = 0, 1, 2, 3. `irqWe` follows `busWe` there. A read returns `irqRdData`, and a write there changes no bank register.
- R8: Every other address, including 0x00, 0x04, addresses above the last bank and addresses not on a 4-byte boundary, reads as zero and ignores writes.
- R9: After reset every line is an input (`padOe` all zero), every value bit is zero, and a mode register reads 0xFF for a full bank.
- R10: In a last bank with fewer than eight lines, the missing lane bits read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busAddr | input | ADDR_W (8) | Byte address of the register access |
| busWe | input | 1 | Write strobe for the current address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data for the previous cycle's address |
| irqRdData | input | 32 | Read data returned by the interrupt block for window addresses |
| irqSel | output | 1 | Current address lies on a word in the interrupt window |
| irqWe | output | 1 | Write strobe into the interrupt window |
| irqIdx | output | 2 | Word index inside the interrupt window |
| padIn | input | NUM_LINES (148) | Asynchronous pad input levels |
| padOut | output | NUM_LINES (148) | Values driven to the pads |
| padOe | output | NUM_LINES (148) | Pad output enables, high for output lines |

## Verification
On every cycle, assertions check four things: no bank decodes inside the interrupt window, bank and window hits never occur together, value and mode registers hold when no write to them occurs, and unmapped addresses read as zero one cycle later. The bench scenarios are the only way to show the exact address of every bank, including the jump past the window, and the bit-by-bit mix of pad and value bits on read-back. The same is true of the two-cycle synchronizer delay, the preload then drive sequence, and the masking of the missing lanes in the partial last bank.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;

  localparam int LANES      = 8;
  localparam int BANK_IDX_W = 8;
  localparam int WIN_LO     = 'h90;
  localparam int WIN_SPAN   = 'h10;

  // strobes from the decoder to the register datapath
  typedef struct packed {
    logic                  bankHit;
    logic                  isDir;
    logic                  wrEn;
    logic [BANK_IDX_W-1:0] bankIdx;
    logic                  winHit;
    logic [1:0]            winIdx;
  } strobe_t;

  // base of bank b, shifted past the interrupt window
  function automatic int unsigned bankBase(int unsigned b);
    int unsigned raw;
    raw = (b + 1) * 8;
    if (raw >= WIN_LO) raw = raw + WIN_SPAN;
    return raw;
  endfunction

endpackage

// File: rtl/pin_bank_decode.sv
module pin_bank_decode
  import pin_bank_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobe_t           strb
);

  localparam logic [ADDR_W-1:0] WinLoA = ADDR_W'(WIN_LO);
  localparam logic [ADDR_W-1:0] WinHiA = ADDR_W'(WIN_LO + WIN_SPAN - 1);

  always_comb begin
    strb = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (busAddr == ADDR_W'(bankBase(b))) begin
        strb.bankHit = 1'b1;
        strb.isDir   = 1'b0;
        strb.bankIdx = BANK_IDX_W'(b);
      end
      if (busAddr == ADDR_W'(bankBase(b) + 4)) begin
        strb.bankHit = 1'b1;
        strb.isDir   = 1'b1;
        strb.bankIdx = BANK_IDX_W'(b);
      end
    end
    if (busAddr >= WinLoA && busAddr <= WinHiA && busAddr[1:0] == 2'b00) begin
      strb.winHit = 1'b1;
      strb.winIdx = busAddr[3:2];
    end
    strb.wrEn = busWe;
  end

  // R2: no bank register decodes inside the interrupt window
  a_r2_no_bank_in_window: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr >= WinLoA && busAddr <= WinHiA) |-> !strb.bankHit);

  // R7: a window access and a bank access never coincide
  a_r7_exclusive_hit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.bankHit, strb.winHit}));

endmodule

// File: rtl/pin_bank_store.sv
module pin_bank_store
  import pin_bank_pkg::*;
#(
  parameter int NUM_LINES = 148,
  parameter int NUM_BANKS = 19
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [31:0]          wrData,
  input  logic [31:0]          irqRdData,
  input  logic [NUM_LINES-1:0] padIn,
  output logic [31:0]          rdData,
  output logic [NUM_LINES-1:0] padOut,
  output logic [NUM_LINES-1:0] padOe
);

  localparam int PadW = NUM_BANKS * LANES;

  logic [PadW-1:0] dataQ;
  logic [PadW-1:0] dirQ;
  logic [PadW-1:0] metaQ;
  logic [PadW-1:0] syncQ;
  logic [PadW-1:0] padWide;
  logic [PadW-1:0] laneMask;

  assign padWide = PadW'(padIn);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int Avail = (NUM_LINES - b * LANES) >= LANES ? LANES : (NUM_LINES - b * LANES);
    localparam logic [LANES-1:0] Mask = LANES'((1 << Avail) - 1);
    logic bankWr;

    assign laneMask[b*LANES +: LANES] = Mask;
    assign bankWr = strb.wrEn && strb.bankHit && (strb.bankIdx == BANK_IDX_W'(b));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dataQ[b*LANES +: LANES] <= '0;
        dirQ[b*LANES +: LANES]  <= Mask;
      end else if (bankWr) begin
        if (strb.isDir) dirQ[b*LANES +: LANES]  <= wrData[LANES-1:0] & Mask;
        else            dataQ[b*LANES +: LANES] <= wrData[LANES-1:0] & Mask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      metaQ <= '0;
      syncQ <= '0;
    end else begin
      metaQ <= padWide & laneMask;
      syncQ <= metaQ;
    end
  end

  logic [LANES-1:0] selData;
  logic [LANES-1:0] selDir;
  logic [LANES-1:0] selPad;
  logic [31:0]      rdNext;

  always_comb begin
    selData = '0;
    selDir  = '0;
    selPad  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strb.bankIdx == BANK_IDX_W'(b)) begin
        selData = dataQ[b*LANES +: LANES];
        selDir  = dirQ[b*LANES +: LANES];
        selPad  = syncQ[b*LANES +: LANES];
      end
    end
    if (strb.bankHit) begin
      if (strb.isDir) rdNext = 32'(selDir);
      else            rdNext = 32'((selDir & selPad) | (~selDir & selData));
    end else if (strb.winHit) begin
      rdNext = irqRdData;
    end else begin
      rdNext = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

  assign padOut = dataQ[NUM_LINES-1:0];
  assign padOe  = ~dirQ[NUM_LINES-1:0];

  // R4: value bits hold unless a value write happens
  a_r4_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrEn && strb.bankHit && !strb.isDir) |=> $stable(dataQ));

  // R3: output enables change only through a mode write
  a_r3_oe_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrEn && strb.bankHit && strb.isDir) |=> $stable(padOe));

  // R8: unmapped addresses read back as zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.bankHit && !strb.winHit) |=> (rdData == 32'h0));

endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
  import pin_bank_pkg::*;
#(
  parameter int NUM_LINES = 148,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  input  logic [31:0]          irqRdData,
  output logic                 irqSel,
  output logic                 irqWe,
  output logic [1:0]           irqIdx,
  input  logic [NUM_LINES-1:0] padIn,
  output logic [NUM_LINES-1:0] padOut,
  output logic [NUM_LINES-1:0] padOe
);

  localparam int NumBanks = (NUM_LINES + LANES - 1) / LANES;

  strobe_t strb;

  pin_bank_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_BANKS (NumBanks)
  ) u_decode (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .strb    (strb)
  );

  pin_bank_store #(
    .NUM_LINES (NUM_LINES),
    .NUM_BANKS (NumBanks)
  ) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (busWrData),
    .irqRdData (irqRdData),
    .padIn     (padIn),
    .rdData    (busRdData),
    .padOut    (padOut),
    .padOe     (padOe)
  );

  assign irqSel = strb.winHit;
  assign irqWe  = strb.winHit && busWe;
  assign irqIdx = strb.winIdx;

endmodule

// File: tb/tb_pin_bank_ctrl.sv
module tb_pin_bank_ctrl;

  localparam int NL = 148;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [7:0]    busAddr = 8'hFC;
  logic          busWe = 1'b0;
  logic [31:0]   busWrData = '0;
  logic [31:0]   busRdData;
  logic [31:0]   irqRdData = 32'hDEADBEEF;
  logic          irqSel, irqWe;
  logic [1:0]    irqIdx;
  logic [NL-1:0] padIn = '0;
  logic [NL-1:0] padOut, padOe;

  pin_bank_ctrl dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWrData(busWrData), .busRdData(busRdData), .irqRdData(irqRdData),
    .irqSel(irqSel), .irqWe(irqWe), .irqIdx(irqIdx),
    .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  always #2.5 clk = ~clk;

  int nCmp = 0;
  int nBad = 0;
  logic [NL-1:0] shData = '0;
  logic [NL-1:0] shOe   = '0;

  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdIssue = 1'b0;
  logic        rdIssueD = 1'b0;

  function automatic int tbBase(int b);
    int a;
    a = 8 * b + 8;
    if (a >= 144) a += 16;
    return a;
  endfunction

  task automatic check(string tag, logic [159:0] act, logic [159:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    busAddr = a; busWe = 1'b1; busWrData = d;
    @(negedge clk);
    busWe = 1'b0; busAddr = 8'hFC;
  endtask

  // write to bank b, updating the shadow model of pads
  task automatic bankWrite(int b, bit isDir, logic [7:0] v);
    for (int k = 0; k < 8; k++) begin
      if (b * 8 + k < NL) begin
        if (isDir) shOe[b*8+k] = ~v[k];
        else       shData[b*8+k] = v[k];
      end
    end
    busWrite(8'(tbBase(b) + (isDir ? 4 : 0)), 32'(v));
  endtask

  task automatic busRead(logic [7:0] a, logic [31:0] e, string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
    busAddr = a; rdIssue = 1'b1;
    @(negedge clk);
    rdIssue = 1'b0; busAddr = 8'hFC;
  endtask

  task automatic padCheck(string tag);
    check({tag, " padOut"}, 160'(padOut), 160'(shData));
    check({tag, " padOe"},  160'(padOe),  160'(shOe));
  endtask

  always @(posedge clk) rdIssueD <= rdIssue;

  // monitor: compare the registered read data against the queue
  always @(negedge clk) begin
    if (rdIssueD) begin
      if (expQ.size() == 0) begin
        nCmp++; nBad++;
        $display("FAIL R1 unexpected read act=%h exp=none", busRdData);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, 160'(busRdData), 160'(e));
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    nCmp++; nBad++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9 reset state
    padCheck("R9 reset");
    busRead(8'h08, 32'h0,  "R9 value after reset");
    busRead(8'h0C, 32'hFF, "R9 mode after reset");

    // R1 R3 bank 0 output
    bankWrite(0, 0, 8'hA5);
    bankWrite(0, 1, 8'h00);
    padCheck("R3 bank0 output");
    busRead(8'h08, 32'hA5, "R1 bank0 value");
    busRead(8'h0C, 32'h00, "R1 bank0 mode");

    // R1 bank 5 at 0x30
    bankWrite(5, 1, 8'h0F);
    busRead(8'h34, 32'h0F, "R1 bank5 mode at 0x34");

    // R4 preload on bank 16 (0x88) then drive
    bankWrite(16, 0, 8'h3C);
    padCheck("R4 preload while input");
    busRead(8'h8C, 32'hFF, "R4 still input");
    bankWrite(16, 1, 8'h00);
    padCheck("R4 drive after preload");
    busRead(8'h88, 32'h3C, "R4 value kept");

    // R2 banks past the window
    bankWrite(17, 0, 8'h5A);
    bankWrite(17, 1, 8'h00);
    padCheck("R2 bank17 at 0xA0");
    busRead(8'hA0, 32'h5A, "R2 bank17 value");

    // R10 partial bank 18 (4 lanes) at 0xA8
    bankWrite(18, 0, 8'hFF);
    bankWrite(18, 1, 8'hF3);
    padCheck("R10 partial bank");
    busRead(8'hAC, 32'h03, "R10 mode lanes masked");
    busRead(8'hA8, 32'h0C, "R10 value lanes masked");

    // R7 interrupt window
    busAddr = 8'h94; busWe = 1'b1; busWrData = 32'hFFFF_FFFF;
    #1;
    check("R7 irqSel", 160'(irqSel), 160'(1));
    check("R7 irqWe",  160'(irqWe),  160'(1));
    check("R7 irqIdx", 160'(irqIdx), 160'(1));
    @(negedge clk);
    busWe = 1'b0; busAddr = 8'h9C;
    #1;
    check("R7 irqIdx 3 no we", 160'({irqSel, irqWe, irqIdx}), 160'(4'b1011));
    busWrite(8'h90, 32'h0);
    busWrite(8'h98, 32'h0);
    padCheck("R7 window write leaves banks");
    busRead(8'h9C, 32'hDEADBEEF, "R7 window read");
    busRead(8'h0C, 32'h00, "R7 bank0 mode kept");

    // R8 unmapped
    busWrite(8'h00, 32'hFF);
    busWrite(8'h04, 32'hFF);
    busWrite(8'hB0, 32'hFF);
    busWrite(8'h0A, 32'hFF);
    busWrite(8'hA2, 32'h00);
    padCheck("R8 unmapped writes ignored");
    busRead(8'h00, 32'h0, "R8 read 0x00");
    busRead(8'hB0, 32'h0, "R8 read 0xB0");
    busRead(8'h0A, 32'h0, "R8 read misaligned");
    busRead(8'h96, 32'h0, "R8 misaligned in window");

    // R6 synchronizer delay on bank 1 (input)
    padIn[15:8] = 8'h96;
    busRead(8'h10, 32'h00, "R6 first read old");
    busRead(8'h10, 32'h00, "R6 second read old");
    busRead(8'h10, 32'h96, "R6 third read new");

    // R5 mixed lanes on bank 1
    bankWrite(1, 0, 8'h50);
    bankWrite(1, 1, 8'h0F);
    busRead(8'h10, 32'h56, "R5 mixed pad and value");
    padIn[7:0] = 8'hFF;
    repeat (3) @(negedge clk);
    busRead(8'h08, 32'hA5, "R5 output ignores pad");
    padCheck("R5 final pads");

    repeat (3) @(negedge clk);
    check("R1 queue drained", 160'(expQ.size()), 160'(0));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule